// File: doc/BRIEF.md
# Key-Driven Permutation Scheduler

This block prepares the 256-byte state table of a byte-oriented stream cipher. Once a controlling state machine raises `start`, it first writes the identity permutation into an external single-port state RAM (location n receives value n). It then walks the table a second time and mixes it under a 24-bit key: a running byte index `j` accumulates the current entry and one key byte, and entries `i` and `j` are exchanged. When the last exchange has been written, it raises `finish` for one clock and returns to idle.

The RAM has one clock and one address port. Writes take effect at the clock edge. Read data appears one clock after its address is presented. Each exchange therefore takes four cycles: fetch entry `i`, fetch entry `j`, store the old `j` value at `i`, and store the old `i` value at `j`. The key byte is chosen by a counter that runs 0, 1, 2 in step with `i`. No divider is used, and all index arithmetic wraps naturally in 8 bits.

States: `ST_IDLE` (waits for `start`), `ST_FILL` (one identity write per cycle), `ST_RD_I`, `ST_RD_J`, `ST_WR_I`, `ST_WR_J` (the four exchange steps), and `ST_DONE` (the `finish` pulse). Transitions: IDLE→FILL on `start`; FILL→FILL until index 255 is written, then FILL→RD_I; RD_I→RD_J→WR_I→WR_J unconditionally; WR_J→RD_I while the index is below 255, otherwise WR_J→DONE; DONE→IDLE.

Top module: `perm_keysched`

## Requirements
- R1: After reset, `mem_we` and `finish` are low, and they stay low while `start` is not asserted.
- R2: A `start` sampled high in idle begins the fill. For 256 consecutive cycles, `mem_we` is high and locations 0 to 255 are written in ascending order, each with its own address as data.
- R3: After a run, the RAM holds the permutation produced by the mixing pass. The pass begins with j = 0 and i = 0. For each i from 0 to 255 it sets j to the low 8 bits of j + s[i] + key byte, then exchanges s[i] and s[j].
- R4: The key byte for index i is chosen by i mod 3. A remainder of 0 selects key bits 23:16, 1 selects bits 15:8, and 2 selects bits 7:0. For example, key 0x000249 yields bytes 0x00, 0x02, 0x49 in that order.
- R5: Each exchange issues exactly two writes in this order: first address i with the old s[j], then address j with the old s[i]. The write to j follows the write to i by one cycle and comes two cycles after the read of j was addressed.
- R6: When j equals i, both writes of the exchange store the unchanged value of that entry.
- R7: `finish` is high for exactly one cycle. It rises 1280 clock edges after the edge that accepted `start`, and the block can then be started again.
- R8: `start` has no effect while a run is in progress or while `finish` is high. The write sequence, the final table and the `finish` timing are unchanged, and no write follows the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only in idle) |
| key | input | 24 | Mixing key; bits 23:16 are used first |
| finish | output | 1 | One-cycle completion pulse |
| mem_addr | output | 8 | State RAM address |
| mem_wdata | output | 8 | State RAM write data |
| mem_we | output | 1 | State RAM write enable |
| mem_rdata | input | 8 | State RAM read data, one cycle after address |

## Verification
The scoreboard predicts every RAM write of a run from a software model of both passes. Stimulus includes the all-zero key, whose first exchange has i equal to j, and the example key 0x000249, whose three bytes differ and so expose any reversed or rotated byte order. Further runs use an all-ones key, which makes `j` wrap on almost every step, and a mixed key during which `start` is pulsed mid-run and on the `finish` cycle, to show that such pulses change neither the write stream nor the completion timing. Each run also compares the final table with the model and measures the `finish` position and width.

// File: rtl/perm_pkg.sv
package perm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD_I,
        ST_RD_J,
        ST_WR_I,
        ST_WR_J,
        ST_DONE
    } ks_state_e;
endpackage

// File: rtl/ks_ctrl.sv
module ks_ctrl
    import perm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      idx_last,
    output ks_state_e state,
    output logic      finish
);
    ks_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_FILL;
            ST_FILL: if (idx_last) state_nx = ST_RD_I;
            ST_RD_I: state_nx = ST_RD_J;
            ST_RD_J: state_nx = ST_WR_I;
            ST_WR_I: state_nx = ST_WR_J;
            ST_WR_J: state_nx = idx_last ? ST_DONE : ST_RD_I;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        finish = (state == ST_DONE);
    end

    // R7
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_J || state == ST_DONE || state == ST_RD_I) |=> state != ST_FILL);
endmodule

// File: rtl/ks_keysel.sv
module ks_keysel #(
    parameter int BYTE_W    = 8,
    parameter int KEY_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        step,
    input  logic [KEY_BYTES*BYTE_W-1:0] key,
    output logic [BYTE_W-1:0]           kbyte
);
    localparam int SEL_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(KEY_BYTES - 1);

    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] kb [KEY_BYTES];

    generate
        for (genvar g = 0; g < KEY_BYTES; g++) begin : g_byte
            assign kb[g] = key[(KEY_BYTES-1-g)*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  sel <= '0;
        else if (step)      sel <= (sel == SEL_LAST) ? '0 : sel + 1'b1;
    end

    assign kbyte = kb[sel];

    // R4
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel <= SEL_LAST);

    // R4
    sel_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && sel == SEL_LAST) |=> sel == '0);
endmodule

// File: rtl/ks_datapath.sv
module ks_datapath
    import perm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ks_state_e         state,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] kbyte,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              idx_last
);
    localparam logic [DATA_W-1:0] IDX_MAX = '1;

    logic [DATA_W-1:0] idx_i, idx_j, held_si, j_next;

    assign j_next   = idx_j + mem_rdata + kbyte;
    assign idx_last = (idx_i == IDX_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_i   <= '0;
            idx_j   <= '0;
            held_si <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx_i <= '0;
                    idx_j <= '0;
                end
                ST_FILL: begin
                    idx_i <= idx_i + 1'b1;
                    idx_j <= '0;
                end
                ST_RD_J: begin
                    held_si <= mem_rdata;
                    idx_j   <= j_next;
                end
                ST_WR_J: idx_i <= idx_i + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr  = idx_i;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (state)
            ST_FILL: begin
                mem_wdata = idx_i;
                mem_we    = 1'b1;
            end
            ST_RD_J: mem_addr = j_next;
            ST_WR_I: begin
                mem_wdata = mem_rdata;
                mem_we    = 1'b1;
            end
            ST_WR_J: begin
                mem_addr  = idx_j;
                mem_wdata = held_si;
                mem_we    = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && $past(state) == ST_FILL) |-> mem_addr == DATA_W'($past(mem_addr) + 1'b1));

    // R5
    swap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_J) |-> mem_addr == $past(mem_addr, 2));

    // R5
    swap_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_J) |-> mem_wdata == $past(mem_rdata, 2));

    // R6
    same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_J && mem_addr == $past(mem_addr, 3)) |-> mem_wdata == $past(mem_rdata));
endmodule

// File: rtl/perm_keysched.sv
module perm_keysched
    import perm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int KEY_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [KEY_BYTES*DATA_W-1:0] key,
    output logic                        finish,
    output logic [DATA_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        mem_we,
    input  logic [DATA_W-1:0]           mem_rdata
);
    ks_state_e         state;
    logic              idx_last;
    logic [DATA_W-1:0] kbyte;

    ks_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .idx_last (idx_last),
        .state    (state),
        .finish   (finish)
    );

    ks_keysel #(.BYTE_W(DATA_W), .KEY_BYTES(KEY_BYTES)) u_keysel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_FILL),
        .step  (state == ST_WR_J),
        .key   (key),
        .kbyte (kbyte)
    );

    ks_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .mem_rdata (mem_rdata),
        .kbyte     (kbyte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .idx_last  (idx_last)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_we && !finish));
endmodule

// File: tb/perm_keysched_bench.sv
module perm_keysched_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] key = '0;
    logic        finish;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata, raddr_q;
    logic        mem_we;

    logic [7:0]  ram [256];
    logic [7:0]  exp_final [256];
    item_t       q [$];
    item_t       it;
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    bit          all_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_keysched u_perm_keysched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key       (key),
        .finish    (finish),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) ram[mem_addr] <= mem_wdata;
        raddr_q <= mem_addr;
    end
    assign mem_rdata = ram[raddr_q];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one predicted write per observed write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R8 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
            end else begin
                it = q.pop_front();
                if (mem_addr !== it.a || mem_wdata !== it.d) begin
                    failures++;
                    $display("FAIL %s write actual=%0h:%0h expected=%0h:%0h",
                             it.tag, mem_addr, mem_wdata, it.a, it.d);
                end
            end
        end
    end

    // driver side: software model of both passes, pushes expected writes
    task automatic predict(input logic [23:0] k);
        logic [7:0] s [256];
        logic [7:0] j = 8'h00;
        logic [7:0] kb, t;
        item_t e;
        for (int n = 0; n < 256; n++) begin
            s[n] = 8'(n);
            e.a = 8'(n); e.d = 8'(n); e.tag = "R2";
            q.push_back(e);
        end
        for (int n = 0; n < 256; n++) begin
            // R4: remainder 0 -> bits 23:16, 1 -> 15:8, 2 -> 7:0
            kb = (n % 3 == 0) ? k[23:16] : (n % 3 == 1) ? k[15:8] : k[7:0];
            j = j + s[n] + kb;
            e.tag = (8'(n) == j) ? "R6" : (n < 3) ? "R4" : "R5";
            e.a = 8'(n); e.d = s[j];
            q.push_back(e);
            e.a = j; e.d = s[n];
            q.push_back(e);
            t = s[n]; s[n] = s[j]; s[j] = t;
        end
        for (int n = 0; n < 256; n++) exp_final[n] = s[n];
    endtask

    task automatic run_key(input logic [23:0] k, input bit poke);
        int s0;
        int waited = 0;
        int diff = 0;
        predict(k);
        @(negedge clk);
        key = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s0 = cyc;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;          // R8: mid-run pulse
            @(negedge clk);
            start = 1'b0;
        end
        while (!finish && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(finish && (cyc - s0 == 1280), "R7", "finish position", cyc - s0, 1280);
        if (poke) start = 1'b1;    // R8: pulse on the finish cycle
        @(negedge clk);
        start = 1'b0;
        check(!finish, "R7", "finish width", int'(finish), 0);
        repeat (3) @(negedge clk);
        check(q.size() == 0, poke ? "R8" : "R5", "pending writes", q.size(), 0);
        q.delete();
        for (int n = 0; n < 256; n++)
            if (ram[n] !== exp_final[n]) diff++;
        check(diff == 0, "R3", "final table mismatches", diff, 0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 4000) @(posedge clk);
        if (!all_done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            check(!mem_we && !finish, "R1", "idle outputs", {mem_we, finish}, 0);
        end
        run_key(24'h000000, 1'b0);   // R6 at i = 0
        run_key(24'h000249, 1'b0);   // R4 byte order
        run_key(24'hFFFFFF, 1'b0);   // R3 heavy wrap
        run_key(24'h5A3C91, 1'b1);   // R8 ignored start pulses
        all_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule